// File: doc/BRIEF.md
# Store Address Generator

This block forms the memory request for the store instructions of a small 32-bit RISC core. From a decoded addressing mode, an access size and the relevant general register values (Rj, R13, R14, R15), it computes the effective byte address. It also expands the narrow, pre-scaled offset fields carried in the instruction. From the address and size it derives a big-endian byte-enable mask and replicates the store data across the selected lanes.

Push forms decrement the stack pointer R15 by four. The decremented value is both the store address and the stack pointer writeback. A push can store a general register, one of the special registers selected by a small index, or the program status word.

All outputs are registered, so a request presented in one cycle appears at the outputs on the next clock edge for exactly one cycle. A misaligned address, or an illegal pairing of mode, size or special-register index, raises a flag instead of a request. No store form touches the condition flags, and the block has no flag output.

Top module: `store_agu`

## Requirements
- R1: Mode 0 (register indirect) stores at address Rj. Every accepted input appears at the outputs one clock later, for one cycle.
- R2: Mode 1 (indexed) stores at address R13 + Rj, with wraparound modulo 2^32.
- R3: Mode 2 with size 2 (word) adds to R14 the 8-bit offset field, sign-extended and multiplied by 4.
- R4: Mode 2 with size 1 (halfword) adds to R14 the 8-bit offset field, sign-extended and multiplied by 2.
- R5: Mode 2 with size 0 (byte) adds to R14 the 8-bit offset field, sign-extended and not scaled.
- R6: Mode 3 (word only) adds to R15 the 4-bit offset field, zero-extended and multiplied by 4, which gives offsets from 0 to 60.
- R7: Mode 4 (push, word only) stores at R15 − 4 and writes that value back as the new R15. The push source select chooses what is stored: 0 for the general register Ri, 1 for a special register, 2 for the status word.
- R8: A push of a special register stores the register at index spr_idx. An index at or above N_SPR is illegal.
- R9: Byte enables use big-endian lanes, with bit 3 as byte address 0. A word enables 1111. A halfword enables 1100 at address bit 1 = 0 and 0011 at address bit 1 = 1. A byte enables 1000, 0100, 0010 or 0001 for address bits [1:0] = 0, 1, 2 or 3.
- R10: Store data is the full word for word stores. For halfword stores it is the low 16 bits written twice. For byte stores it is the low byte written four times.
- R11: A word store with address bits [1:0] ≠ 00, or a halfword store with address bit 0 set, sets st_misal. The request is not issued and its byte enables are zero.
- R12: A non-word size in mode 3 or 4, size code 3, mode codes 5 to 7, or push source code 3 sets st_illegal. The request is not issued.
- R13: sp_we is high only in the cycle of an issued push request. It is never high for other modes or for a flagged push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Store request present this cycle |
| mode | input | 3 | Addressing mode (0 ind, 1 idx, 2 frame, 3 stack, 4 push) |
| size | input | 2 | Access size (0 byte, 1 half, 2 word) |
| push_src | input | 2 | Push source (0 Ri, 1 special, 2 status) |
| spr_idx | input | $clog2(N_SPR) | Special register index |
| rj_val | input | 32 | Rj contents |
| r13_val | input | 32 | R13 contents |
| r14_val | input | 32 | R14 contents |
| r15_val | input | 32 | R15 contents |
| ri_val | input | 32 | Ri contents (store source) |
| spr_flat | input | 32*N_SPR | Special registers, index k at bits [32k+31:32k] |
| ps_val | input | 32 | Program status word |
| ofs8 | input | 8 | Frame offset field |
| ofs4 | input | 4 | Stack offset field |
| st_vld | output | 1 | Store request issued |
| st_addr | output | 32 | Effective byte address |
| st_be | output | 4 | Byte enables, big-endian lanes |
| st_data | output | 32 | Lane-replicated store data |
| st_misal | output | 1 | Misaligned access flag |
| st_illegal | output | 1 | Illegal form flag |
| sp_we | output | 1 | R15 writeback enable |
| sp_val | output | 32 | New R15 value |

## Verification
The bench builds the block with its default of six special registers, which gives a 3-bit index. With this width the unused codes 6 and 7 are reachable, so the illegal-index path can be driven. Offset fields are driven at both sign extremes, so the sign extension of each scaling factor is exercised. Stack offsets are driven at their maximum, and sums that wrap past 2^32 are included. Pushes from R15 values that are not word-aligned cover the interaction of the pre-decrement with the misalignment check.

// File: rtl/store_agu.sv
module store_agu #(
  parameter int N_SPR = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [2:0]              mode,
  input  logic [1:0]              size,
  input  logic [1:0]              push_src,
  input  logic [$clog2(N_SPR)-1:0] spr_idx,
  input  logic [31:0]             rj_val,
  input  logic [31:0]             r13_val,
  input  logic [31:0]             r14_val,
  input  logic [31:0]             r15_val,
  input  logic [31:0]             ri_val,
  input  logic [32*N_SPR-1:0]     spr_flat,
  input  logic [31:0]             ps_val,
  input  logic [7:0]              ofs8,
  input  logic [3:0]              ofs4,
  output logic                    st_vld,
  output logic [31:0]             st_addr,
  output logic [3:0]              st_be,
  output logic [31:0]             st_data,
  output logic                    st_misal,
  output logic                    st_illegal,
  output logic                    sp_we,
  output logic [31:0]             sp_val
);
  localparam int IW = $clog2(N_SPR);

  logic [31:0] base, ofs, ea, src, wd, spr_sel;
  logic [3:0]  be;
  logic        ill, mis, ok, is_push;

  assign is_push = (mode == 3'd4);

  always_comb begin
    spr_sel = '0;
    for (int k = 0; k < N_SPR; k++)
      if (spr_idx == IW'(k)) spr_sel = spr_flat[32*k +: 32];
  end

  always_comb begin
    base = rj_val;
    ofs  = '0;
    ill  = (size == 2'd3);
    case (mode)
      3'd0: base = rj_val;
      3'd1: begin base = r13_val; ofs = rj_val; end
      3'd2: begin
        base = r14_val;
        case (size)
          2'd2:    ofs = {{22{ofs8[7]}}, ofs8, 2'b00};
          2'd1:    ofs = {{23{ofs8[7]}}, ofs8, 1'b0};
          default: ofs = {{24{ofs8[7]}}, ofs8};
        endcase
      end
      3'd3: begin
        base = r15_val;
        ofs  = {26'd0, ofs4, 2'b00};
        if (size != 2'd2) ill = 1'b1;
      end
      3'd4: begin
        base = r15_val;
        ofs  = 32'hFFFF_FFFC;
        if (size != 2'd2) ill = 1'b1;
        if (push_src == 2'd3) ill = 1'b1;
        if (push_src == 2'd1 && int'(spr_idx) >= N_SPR) ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
  end

  assign ea = base + ofs;

  always_comb begin
    src = ri_val;
    if (is_push) begin
      case (push_src)
        2'd1:    src = spr_sel;
        2'd2:    src = ps_val;
        default: src = ri_val;
      endcase
    end
  end

  always_comb begin
    case (size)
      2'd0: begin
        wd = {4{src[7:0]}};
        be = 4'b1000 >> ea[1:0];
      end
      2'd1: begin
        wd = {2{src[15:0]}};
        be = ea[1] ? 4'b0011 : 4'b1100;
      end
      default: begin
        wd = src;
        be = 4'b1111;
      end
    endcase
  end

  assign mis = ((size == 2'd2) && (ea[1:0] != 2'b00)) ||
               ((size == 2'd1) && ea[0]);
  assign ok  = in_vld && !mis && !ill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_vld     <= 1'b0;
      st_addr    <= '0;
      st_be      <= '0;
      st_data    <= '0;
      st_misal   <= 1'b0;
      st_illegal <= 1'b0;
      sp_we      <= 1'b0;
      sp_val     <= '0;
    end else begin
      st_vld     <= ok;
      st_addr    <= ea;
      st_be      <= ok ? be : 4'b0000;
      st_data    <= wd;
      st_misal   <= in_vld && !ill && mis;
      st_illegal <= in_vld && ill;
      sp_we      <= ok && is_push;
      sp_val     <= ea;
    end
  end
endmodule

module store_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic        st_vld,
  input logic [31:0] st_addr,
  input logic [3:0]  st_be,
  input logic        st_misal,
  input logic        st_illegal,
  input logic        sp_we,
  input logic [31:0] sp_val
);
  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n) st_vld |-> $past(in_vld)); // R1
  AST_VLD_NO_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) st_vld |-> (!st_misal && !st_illegal)); // R11
  AST_WORD_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) (st_vld && st_be == 4'hF) |-> st_addr[1:0] == 2'b00); // R11
  AST_BE_SHAPE:      assert property (@(posedge clk) disable iff (!rst_n) st_vld |-> ($countones(st_be) == 1 || $countones(st_be) == 2 || $countones(st_be) == 4)); // R9
  AST_SP_WE_REQ:     assert property (@(posedge clk) disable iff (!rst_n) sp_we |-> st_vld); // R13
  AST_SP_MATCH:      assert property (@(posedge clk) disable iff (!rst_n) sp_we |-> sp_val == st_addr); // R7
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !st_vld |-> (st_be == 4'h0 && !sp_we)); // R13
  AST_FLAGS_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(st_misal && st_illegal)); // R12
endmodule

bind store_agu store_agu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .st_vld(st_vld),
  .st_addr(st_addr), .st_be(st_be), .st_misal(st_misal),
  .st_illegal(st_illegal), .sp_we(sp_we), .sp_val(sp_val)
);

// File: tb/store_agu_tb.sv
module store_agu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SPR = 6;

  logic clk = 0, rst_n = 0, in_vld = 0;
  logic [2:0] mode = 0;
  logic [1:0] size = 0, push_src = 0;
  logic [2:0] spr_idx = 0;
  logic [31:0] rj_val = 0, r13_val = 0, r14_val = 0, r15_val = 0, ri_val = 0, ps_val = 0;
  logic [32*N_SPR-1:0] spr_flat;
  logic [7:0] ofs8 = 0;
  logic [3:0] ofs4 = 0;
  logic st_vld, st_misal, st_illegal, sp_we;
  logic [31:0] st_addr, st_data, sp_val;
  logic [3:0] st_be;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_agu #(.N_SPR(N_SPR)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .size(size),
    .push_src(push_src), .spr_idx(spr_idx), .rj_val(rj_val), .r13_val(r13_val),
    .r14_val(r14_val), .r15_val(r15_val), .ri_val(ri_val), .spr_flat(spr_flat),
    .ps_val(ps_val), .ofs8(ofs8), .ofs4(ofs4), .st_vld(st_vld), .st_addr(st_addr),
    .st_be(st_be), .st_data(st_data), .st_misal(st_misal), .st_illegal(st_illegal),
    .sp_we(sp_we), .sp_val(sp_val)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] s);
    @(negedge clk);
    mode = m; size = s; in_vld = 1;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic expect_req(input string req, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    chk(st_vld === 1'b1, req, {31'd0, st_vld}, 32'd1);
    chk(st_addr === a, req, st_addr, a);
    chk(st_be === be, req, {28'd0, st_be}, {28'd0, be});
    chk(st_data === d, req, st_data, d);
  endtask

  task automatic t_reset;
    chk(st_vld === 0 && st_be === 0 && sp_we === 0 && st_misal === 0 && st_illegal === 0,
        "R1 reset", {st_vld, st_be, sp_we, st_misal, st_illegal}, 32'd0);
  endtask

  task automatic t_indirect;
    rj_val = 32'h0000_4000; ri_val = 32'h1234_5678;
    issue(3'd0, 2'd2);
    expect_req("R1 indirect word", 32'h4000, 4'hF, 32'h1234_5678);
    chk(sp_we === 0, "R13 no wb indirect", {31'd0, sp_we}, 0);
    @(negedge clk);
    chk(st_vld === 0, "R1 single cycle", {31'd0, st_vld}, 0);
  endtask

  task automatic t_indexed;
    r13_val = 32'hFFFF_FFF0; rj_val = 32'h0000_0020; ri_val = 32'hA5A5_1234;
    issue(3'd1, 2'd1);
    expect_req("R2 indexed wrap", 32'h0000_0010, 4'b1100, 32'h1234_1234);
  endtask

  task automatic t_frame;
    r14_val = 32'h0000_1000; ri_val = 32'hAABB_CCDD;
    ofs8 = 8'hFF; issue(3'd2, 2'd2);
    expect_req("R3 word neg", 32'h0FFC, 4'hF, 32'hAABB_CCDD);
    ofs8 = 8'h7F; issue(3'd2, 2'd2);
    expect_req("R3 word pos", 32'h11FC, 4'hF, 32'hAABB_CCDD);
    ofs8 = 8'h80; issue(3'd2, 2'd1);
    expect_req("R4 half neg", 32'h0F00, 4'b1100, 32'hCCDD_CCDD);
    ofs8 = 8'h01; issue(3'd2, 2'd1);
    expect_req("R4 R9 half hi lanes", 32'h1002, 4'b0011, 32'hCCDD_CCDD);
    ofs8 = 8'h81; issue(3'd2, 2'd0);
    expect_req("R5 byte neg", 32'h0F81, 4'b0100, 32'hDDDD_DDDD);
    ofs8 = 8'h7F; issue(3'd2, 2'd0);
    expect_req("R5 R10 byte pos", 32'h107F, 4'b0001, 32'hDDDD_DDDD);
    ofs8 = 8'h02; issue(3'd2, 2'd0);
    expect_req("R9 byte lane2", 32'h1002, 4'b0010, 32'hDDDD_DDDD);
    ofs8 = 8'h00; issue(3'd2, 2'd0);
    expect_req("R9 byte lane0", 32'h1000, 4'b1000, 32'hDDDD_DDDD);
  endtask

  task automatic t_stack;
    r15_val = 32'h0000_2000; ri_val = 32'h0BAD_F00D;
    ofs4 = 4'hF; issue(3'd3, 2'd2);
    expect_req("R6 udisp max", 32'h203C, 4'hF, 32'h0BAD_F00D);
    chk(sp_we === 0, "R13 no wb stack", {31'd0, sp_we}, 0);
    ofs4 = 4'h0; issue(3'd3, 2'd2);
    expect_req("R6 udisp zero", 32'h2000, 4'hF, 32'h0BAD_F00D);
  endtask

  task automatic t_push;
    r15_val = 32'h0000_3000; ri_val = 32'h1111_2222; ps_val = 32'h0000_00F5;
    push_src = 2'd0; issue(3'd4, 2'd2);
    expect_req("R7 push Ri", 32'h2FFC, 4'hF, 32'h1111_2222);
    chk(sp_we === 1 && sp_val === 32'h2FFC, "R7 R13 sp wb", sp_val, 32'h2FFC);
    push_src = 2'd2; issue(3'd4, 2'd2);
    expect_req("R7 push PS", 32'h2FFC, 4'hF, 32'h0000_00F5);
    push_src = 2'd1; spr_idx = 3'd5; issue(3'd4, 2'd2);
    expect_req("R8 push spr5", 32'h2FFC, 4'hF, 32'h5000_0005);
    spr_idx = 3'd0; issue(3'd4, 2'd2);
    expect_req("R8 push spr0", 32'h2FFC, 4'hF, 32'h5000_0000);
    spr_idx = 3'd6; issue(3'd4, 2'd2);
    chk(st_vld === 0 && st_illegal === 1 && sp_we === 0, "R8 bad index", {st_vld, st_illegal, sp_we}, 32'b010);
    push_src = 2'd0; spr_idx = 0;
  endtask

  task automatic t_misalign;
    rj_val = 32'h0000_0102; ri_val = 32'h1234_5678;
    issue(3'd0, 2'd2);
    chk(st_vld === 0 && st_misal === 1 && st_be === 0, "R11 word misal", {st_vld, st_misal, st_be}, 32'b0_1_0000);
    rj_val = 32'h0000_0103;
    issue(3'd0, 2'd1);
    chk(st_vld === 0 && st_misal === 1, "R11 half misal", {st_vld, st_misal}, 32'b01);
    issue(3'd0, 2'd0);
    chk(st_vld === 1 && st_misal === 0 && st_be === 4'b0001, "R11 byte any", {st_vld, st_misal, st_be}, 32'b1_0_0001);
    r15_val = 32'h0000_3002;
    issue(3'd4, 2'd2);
    chk(st_vld === 0 && st_misal === 1 && sp_we === 0, "R11 R13 push misal", {st_vld, st_misal, sp_we}, 32'b010);
  endtask

  task automatic t_illegal;
    r15_val = 32'h0000_2000;
    issue(3'd3, 2'd0);
    chk(st_vld === 0 && st_illegal === 1, "R12 stack byte", {st_vld, st_illegal}, 32'b01);
    issue(3'd4, 2'd1);
    chk(st_vld === 0 && st_illegal === 1 && sp_we === 0, "R12 push half", {st_vld, st_illegal, sp_we}, 32'b010);
    issue(3'd6, 2'd2);
    chk(st_vld === 0 && st_illegal === 1, "R12 bad mode", {st_vld, st_illegal}, 32'b01);
    issue(3'd0, 2'd3);
    chk(st_vld === 0 && st_illegal === 1, "R12 bad size", {st_vld, st_illegal}, 32'b01);
    push_src = 2'd3; issue(3'd4, 2'd2);
    chk(st_vld === 0 && st_illegal === 1, "R12 bad src", {st_vld, st_illegal}, 32'b01);
    push_src = 2'd0;
  endtask

  initial begin
    for (int k = 0; k < N_SPR; k++) spr_flat[32*k +: 32] = 32'h5000_0000 + k;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_indirect();
    t_indexed();
    t_frame();
    t_stack();
    t_push();
    t_misalign();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule